// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm and Periodic Interrupts

This block keeps the time of day and a 100-year calendar as packed BCD bytes: second, minute, hour (24-hour), date, month and two-digit year. It is driven by a one-cycle `tick` enable from a 32.768 kHz timebase. A prescaler counts `PRESCALE` ticks per second, and every second it moves the calendar forward by one step. Carries ripple through every field in that same step. The month length follows the month value, and February is lengthened in years divisible by four.

Software writes the time, the alarm and a control byte through a simple write port. An alarm flag is raised when all unmasked alarm fields equal the running time. Masking fields from the top down gives an alarm that repeats every second, minute, hour, day or month. A periodic flag is raised on every 2^n timebase ticks, taken from the same prescaler. Both flags are sticky and are cleared by a flag-read strobe. A single active-low interrupt line combines the flags that are enabled. Counting and alarm matching depend only on `tick`, so they carry on while the rest of the system is powered down and the alarm can serve as a wake-up event.

Top module: `bcd_rtc`

## Requirements
- R1: After `rst` the outputs read second 8'h00, minute 8'h00, hour 8'h00, date 8'h01, month 8'h01, year 8'h00. Both flags are 0 and `irq_n` is 1. Every field holds packed BCD: upper digit in bits [7:4], lower digit in bits [3:0].
- R2: The seconds field steps on the `PRESCALE`-th tick after reset or after the last time write. The new value appears at the clock edge that samples that tick.
- R3: Second 59 wraps to 00 and increments the minute. Minute 59 wraps to 00 and increments the hour. Hour 23 wraps to 00 and increments the date, all in the same step.
- R4: A step from the last day of a month sets the date to 01 and increments the month. Month 12 wraps to 01 and increments the year. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. For month 02 it is 29 when the year value is divisible by 4 and 28 otherwise.
- R5: The year counts 00 to 99 and wraps from 99 to 00.
- R6: A write (`wr_en`=1) to address 0 through 5 (second, minute, hour, date, month, year) loads `wr_data` into that field at the next edge. It also restarts the prescaler, so the next step comes a full `PRESCALE` ticks later. A step that falls due in the write cycle is dropped.
- R7: Addresses 6 through 9 hold the alarm second, minute, hour and date. Bit 7 of each is a don't-care mask, and bits [6:0] are compared with the field. The alarm flag sets one edge after a step that leaves every unmasked field equal.
- R8: Address 10 holds the control byte. Bits [3:0] are the rate n, bit 4 enables the alarm interrupt and bit 5 enables the periodic interrupt. The periodic flag sets on every 2^min(n, log2 PRESCALE)-th tick, counted from the prescaler restart. Rate 0 never sets it.
- R9: Flags stay set until `rd_flags` is high for a cycle, which clears both at that edge. A flag whose set event falls in that same cycle stays set.
- R10: `irq_n` is 0 exactly when the alarm flag and its enable are both set, or the periodic flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| rd_flags | input | 1 | Flag-read strobe; clears the flags |
| t_sec | output | 8 | BCD seconds |
| t_min | output | 8 | BCD minutes |
| t_hour | output | 8 | BCD hours |
| t_date | output | 8 | BCD day of month |
| t_month | output | 8 | BCD month |
| t_year | output | 8 | BCD year |
| alarm_flag | output | 1 | Sticky alarm flag |
| periodic_flag | output | 1 | Sticky periodic flag |
| irq_n | output | 1 | Combined active-low interrupt |

## Verification
Two pairs of events can land in the same cycle: a flag-read strobe together with a periodic hit, and a seconds write together with the tick that completes a second. The bench drives `rd_flags` high in the very tick cycle where the rate predicts a hit, and expects the flag to survive that read and to clear on the next read. It also drives a seconds write in the cycle where the prescaler wraps. It expects the written value, an unchanged minute, and the next step only a full second of ticks later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int FIELD_W    = 8;
    localparam int ADDR_W     = 4;
    localparam int ALM_FIELDS = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEC      = 4'd0,
        REG_MIN      = 4'd1,
        REG_HOUR     = 4'd2,
        REG_DATE     = 4'd3,
        REG_MONTH    = 4'd4,
        REG_YEAR     = 4'd5,
        REG_ALM_SEC  = 4'd6,
        REG_ALM_MIN  = 4'd7,
        REG_ALM_HOUR = 4'd8,
        REG_ALM_DATE = 4'd9,
        REG_CTRL     = 4'd10
    } reg_addr_e;

    typedef struct packed {
        logic [FIELD_W-1:0] year;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] minute;
        logic [FIELD_W-1:0] second;
    } rtc_time_t;

    typedef struct packed {
        logic       per_en;
        logic       alm_en;
        logic [3:0] rate;
    } ctrl_t;

    localparam rtc_time_t TIME_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                         hour: 8'h00, minute: 8'h00, second: 8'h00};

    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [FIELD_W-1:0] y);
        logic [6:0] bin;
        bin = {3'b000, y[7:4]} * 7'd10 + {3'b000, y[3:0]};
        return bin[1:0] == 2'b00;
    endfunction

    function automatic logic [FIELD_W-1:0] last_day(input logic [FIELD_W-1:0] mon,
                                                    input logic [FIELD_W-1:0] y);
        if (mon == 8'h02)
            return is_leap(y) ? 8'h29 : 8'h28;
        if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11)
            return 8'h30;
        return 8'h31;
    endfunction

    function automatic rtc_time_t calendar_step(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.second != 8'h59) begin
            n.second = bcd_inc(t.second);
        end else begin
            n.second = 8'h00;
            if (t.minute != 8'h59) begin
                n.minute = bcd_inc(t.minute);
            end else begin
                n.minute = 8'h00;
                if (t.hour != 8'h23) begin
                    n.hour = bcd_inc(t.hour);
                end else begin
                    n.hour = 8'h00;
                    if (t.date != last_day(t.month, t.year)) begin
                        n.date = bcd_inc(t.date);
                    end else begin
                        n.date = 8'h01;
                        if (t.month != 8'h12) begin
                            n.month = bcd_inc(t.month);
                        end else begin
                            n.month = 8'h01;
                            n.year  = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

    function automatic logic field_match(input logic [FIELD_W-1:0] alm,
                                         input logic [FIELD_W-1:0] val);
        return alm[7] || (alm[6:0] == val[6:0]);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       restart,
    input  logic [3:0] rate,
    output logic       sec_pulse,
    output logic       per_hit
);
    localparam int PW = $clog2(PRESCALE);

    logic [PW-1:0] count_q;
    logic [PW-1:0] rate_mask;

    always_comb begin
        for (int i = 0; i < PW; i++)
            rate_mask[i] = (i < int'(rate));
    end

    assign sec_pulse = tick && !restart && (&count_q);
    assign per_hit   = tick && !restart && (rate != 4'd0) && (&(count_q | ~rate_mask));

    always_ff @(posedge clk) begin
        if (rst || restart)
            count_q <= '0;
        else if (tick)
            count_q <= count_q + 1'b1;
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    output rtc_time_t          now_o
);
    rtc_time_t now_q;
    rtc_time_t next_t;

    assign next_t = calendar_step(now_q);
    assign now_o  = now_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q <= TIME_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                REG_SEC:   now_q.second <= wr_data;
                REG_MIN:   now_q.minute <= wr_data;
                REG_HOUR:  now_q.hour   <= wr_data;
                REG_DATE:  now_q.date   <= wr_data;
                REG_MONTH: now_q.month  <= wr_data;
                REG_YEAR:  now_q.year   <= wr_data;
                default:   if (advance) now_q <= next_t;
            endcase
        end else if (advance) begin
            now_q <= next_t;
        end
    end

endmodule

// File: rtl/rtc_events.sv
module rtc_events
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    input  logic               per_hit,
    input  logic               rd_flags,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    input  rtc_time_t          now_i,
    output logic [3:0]         rate_o,
    output logic               alarm_flag_o,
    output logic               per_flag_o,
    output logic               irq_n_o
);
    ctrl_t                   ctrl_q;
    logic                    step_q;
    logic                    alarm_q;
    logic                    per_q;
    logic                    alarm_set;
    logic [FIELD_W-1:0]      now_field [ALM_FIELDS];
    logic [ALM_FIELDS-1:0]   field_ok;

    assign now_field[0] = now_i.second;
    assign now_field[1] = now_i.minute;
    assign now_field[2] = now_i.hour;
    assign now_field[3] = now_i.date;

    for (genvar g = 0; g < ALM_FIELDS; g++) begin : g_alm
        logic [FIELD_W-1:0] alm_q;
        always_ff @(posedge clk) begin
            if (rst)
                alm_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(int'(REG_ALM_SEC) + g))
                alm_q <= wr_data;
        end
        assign field_ok[g] = field_match(alm_q, now_field[g]);
    end

    assign alarm_set = step_q && (&field_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            step_q  <= 1'b0;
            alarm_q <= 1'b0;
            per_q   <= 1'b0;
        end else begin
            if (wr_en && wr_addr == REG_CTRL)
                ctrl_q <= ctrl_t'(wr_data[5:0]);
            step_q  <= advance;
            alarm_q <= alarm_set | (alarm_q & ~rd_flags);
            per_q   <= per_hit   | (per_q   & ~rd_flags);
        end
    end

    assign rate_o       = ctrl_q.rate;
    assign alarm_flag_o = alarm_q;
    assign per_flag_o   = per_q;
    assign irq_n_o      = !((alarm_q && ctrl_q.alm_en) || (per_q && ctrl_q.per_en));

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_flags,
    output logic [7:0] t_sec,
    output logic [7:0] t_min,
    output logic [7:0] t_hour,
    output logic [7:0] t_date,
    output logic [7:0] t_month,
    output logic [7:0] t_year,
    output logic       alarm_flag,
    output logic       periodic_flag,
    output logic       irq_n
);
    logic       time_wr;
    logic       sec_pulse;
    logic       per_hit;
    logic [3:0] rate;
    rtc_time_t  now;

    assign time_wr = wr_en && (wr_addr <= REG_YEAR);

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_prescale (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .restart   (time_wr),
        .rate      (rate),
        .sec_pulse (sec_pulse),
        .per_hit   (per_hit)
    );

    rtc_calendar u_cal (
        .clk     (clk),
        .rst     (rst),
        .advance (sec_pulse),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .now_o   (now)
    );

    rtc_events u_evt (
        .clk          (clk),
        .rst          (rst),
        .advance      (sec_pulse),
        .per_hit      (per_hit),
        .rd_flags     (rd_flags),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .now_i        (now),
        .rate_o       (rate),
        .alarm_flag_o (alarm_flag),
        .per_flag_o   (periodic_flag),
        .irq_n_o      (irq_n)
    );

    assign t_sec   = now.second;
    assign t_min   = now.minute;
    assign t_hour  = now.hour;
    assign t_date  = now.date;
    assign t_month = now.month;
    assign t_year  = now.year;

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       rd_flags,
    input logic       per_hit,
    input logic [7:0] t_sec,
    input logic [7:0] t_year,
    input logic       alarm_flag,
    input logic       periodic_flag,
    input logic       irq_n
);

    AST_SEC_BCD: assert property (@(posedge clk) disable iff (rst)
        (t_sec[3:0] <= 4'd9) && (t_sec[7:4] <= 4'd5)); // R1

    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && $past(t_year) == 8'h99 && t_year != 8'h99) |-> (t_year == 8'h00)); // R5

    AST_SEC_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 4'd0) |=> (t_sec == $past(wr_data))); // R6

    AST_PER_SET: assert property (@(posedge clk) disable iff (rst)
        per_hit |=> periodic_flag); // R8

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_flags && !per_hit) |=> !periodic_flag); // R9

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!alarm_flag && !periodic_flag) |-> irq_n); // R10

endmodule

bind bcd_rtc rtc_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_flags      (rd_flags),
    .per_hit       (per_hit),
    .t_sec         (t_sec),
    .t_year        (t_year),
    .alarm_flag    (alarm_flag),
    .periodic_flag (periodic_flag),
    .irq_n         (irq_n)
);

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 16;
    localparam int PRE_LOG    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_flags = 1'b0;
    logic [7:0] t_sec, t_min, t_hour, t_date, t_month, t_year;
    logic       alarm_flag, periodic_flag, irq_n;

    int total = 0;
    int bad   = 0;
    int es, em, eh, ed, emo, ey;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc #(.PRESCALE(PRE)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_flags(rd_flags), .t_sec(t_sec), .t_min(t_min),
        .t_hour(t_hour), .t_date(t_date), .t_month(t_month), .t_year(t_year),
        .alarm_flag(alarm_flag), .periodic_flag(periodic_flag), .irq_n(irq_n)
    );

    function automatic int dim(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] bcd(int v);
        return 8'((v / 10) * 16 + v % 10);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        es++;
        if (es == 60) begin
            es = 0; em++;
            if (em == 60) begin
                em = 0; eh++;
                if (eh == 24) begin
                    eh = 0; ed++;
                    if (ed > dim(emo, ey)) begin
                        ed = 1; emo++;
                        if (emo == 13) begin
                            emo = 1; ey = (ey + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check_time(string req);
        chk({req, " sec"},   t_sec,   bcd(es));
        chk({req, " min"},   t_min,   bcd(em));
        chk({req, " hour"},  t_hour,  bcd(eh));
        chk({req, " date"},  t_date,  bcd(ed));
        chk({req, " month"}, t_month, bcd(emo));
        chk({req, " year"},  t_year,  bcd(ey));
    endtask

    task automatic cyc(logic tk, logic rd);
        @(negedge clk);
        tick = tk; rd_flags = rd;
        @(negedge clk);
        tick = 1'b0; rd_flags = 1'b0;
    endtask

    task automatic write_reg(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(int s, int m, int h, int d, int mo, int y);
        write_reg(0, bcd(s)); write_reg(1, bcd(m)); write_reg(2, bcd(h));
        write_reg(3, bcd(d)); write_reg(4, bcd(mo)); write_reg(5, bcd(y));
        es = s; em = m; eh = h; ed = d; emo = mo; ey = y;
    endtask

    task automatic one_second();
        repeat (PRE) cyc(1'b1, 1'b0);
        model_step();
    endtask

    function automatic logic [7:0] alm_code(int v);
        return (v < 0) ? 8'h80 : bcd(v);
    endfunction

    // R7: run nsec seconds; the flag is expected where every compared field matches
    task automatic alarm_sweep(string req, int nsec, int as, int am, int ah, int ad);
        logic exp;
        write_reg(6, alm_code(as)); write_reg(7, alm_code(am));
        write_reg(8, alm_code(ah)); write_reg(9, alm_code(ad));
        cyc(1'b0, 1'b1);
        for (int k = 0; k < nsec; k++) begin
            one_second();
            @(negedge clk);
            exp = (as < 0 || es == as) && (am < 0 || em == am) &&
                  (ah < 0 || eh == ah) && (ad < 0 || ed == ad);
            chk(req, alarm_flag, exp);
            cyc(1'b0, 1'b1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p;
        logic exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        es = 0; em = 0; eh = 0; ed = 1; emo = 1; ey = 0;
        check_time("R1 reset");
        chk("R1 alarm flag", alarm_flag, 0);
        chk("R1 periodic flag", periodic_flag, 0);
        chk("R1 irq_n", irq_n, 1);

        // R2 step on PRESCALE-th tick
        repeat (PRE - 1) cyc(1'b1, 1'b0);
        chk("R2 before step", t_sec, 8'h00);
        cyc(1'b1, 1'b0);
        model_step();
        chk("R2 step", t_sec, bcd(es));

        // R3 second-by-second sweep across minute and hour carries
        set_time(30, 58, 0, 1, 1, 0);
        for (int k = 0; k < 100; k++) begin
            one_second();
            check_time("R3");
        end

        // R4 / R5 last-day rollover over every month of every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                set_time(59, 59, 23, dim(m, y), m, y);
                one_second();
                check_time((y == 99 && m == 12) ? "R5 wrap" : "R4 month end");
                if (m == 2) begin
                    set_time(59, 59, 23, 28, 2, y);
                    one_second();
                    check_time("R4 february 28");
                end
            end
        end

        // R6 write restarts prescaler
        set_time(0, 0, 0, 1, 1, 0);
        repeat (7) cyc(1'b1, 1'b0);
        write_reg(0, 8'h30);
        repeat (PRE - 1) cyc(1'b1, 1'b0);
        chk("R6 restart hold", t_sec, 8'h30);
        cyc(1'b1, 1'b0);
        chk("R6 restart step", t_sec, 8'h31);

        // R6 write in the same cycle as a due step
        repeat (PRE - 1) cyc(1'b1, 1'b0);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h10;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R6 collision sec", t_sec, 8'h10);
        chk("R6 collision min", t_min, 8'h00);
        repeat (PRE - 1) cyc(1'b1, 1'b0);
        chk("R6 collision hold", t_sec, 8'h10);
        cyc(1'b1, 1'b0);
        chk("R6 collision step", t_sec, 8'h11);

        // R7 alarm modes; control: alarm enable only
        write_reg(10, 8'h10);
        set_time(0, 0, 0, 1, 1, 0);
        write_reg(6, 8'h80); write_reg(7, 8'h80); write_reg(8, 8'h80); write_reg(9, 8'h80);
        cyc(1'b0, 1'b1);
        repeat (PRE) cyc(1'b1, 1'b0);
        model_step();
        chk("R7 latency", alarm_flag, 0);
        @(negedge clk);
        chk("R7 every second", alarm_flag, 1);
        chk("R10 alarm irq", irq_n, 0);
        cyc(1'b0, 1'b1);
        chk("R9 alarm cleared", alarm_flag, 0);

        set_time(58, 0, 0, 1, 1, 0);
        alarm_sweep("R7 per minute", 9, 5, -1, -1, -1);
        set_time(57, 59, 0, 1, 1, 0);
        alarm_sweep("R7 per hour", 5, 0, 0, -1, -1);
        set_time(58, 59, 0, 1, 1, 0);
        alarm_sweep("R7 per day", 4, 0, 0, 1, -1);
        set_time(58, 59, 23, 1, 1, 0);
        alarm_sweep("R7 per month", 4, 0, 0, 0, 2);
        set_time(58, 59, 23, 1, 1, 0);
        alarm_sweep("R7 month mismatch", 4, 0, 0, 0, 3);

        // R8 periodic rates
        for (int n = 0; n < 7; n++) begin
            write_reg(10, 8'(32 + n));
            write_reg(0, 8'h00);
            cyc(1'b0, 1'b1);
            p = 1 << ((n < PRE_LOG) ? n : PRE_LOG);
            for (int k = 1; k <= 40; k++) begin
                cyc(1'b1, 1'b0);
                exp = (n != 0) && (k % p == 0);
                chk("R8 periodic", periodic_flag, exp);
                cyc(1'b0, 1'b1);
            end
        end

        // R9 read in the same cycle as a periodic hit
        write_reg(10, 8'h21);
        write_reg(0, 8'h00);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        chk("R9 no hit", periodic_flag, 0);
        cyc(1'b1, 1'b1);
        chk("R9 set wins", periodic_flag, 1);
        cyc(1'b0, 1'b1);
        chk("R9 read clears", periodic_flag, 0);
        cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9 sticky", periodic_flag, 1);

        // R10 enable gating
        write_reg(10, 8'h01);
        chk("R10 masked", irq_n, 1);
        write_reg(10, 8'h21);
        chk("R10 enabled", irq_n, 0);
        cyc(1'b0, 1'b1);
        chk("R10 released", irq_n, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule